// File: doc/BRIEF.md
# BCD ASCII Adjust Unit

This unit performs the six decimal-correction steps that follow binary arithmetic on decimal digits. It acts on a 16-bit accumulator split into a high byte and a low byte. The steps are an add and a subtract correction for unpacked digits (one digit per byte), a correction that splits a binary byte into two digits after a multiply, a step that merges two digits into one binary byte before a divide, and an add and a subtract correction for packed digits (two digits per byte). The incoming carry and auxiliary-carry flags steer the corrections. The unit returns the corrected bytes together with new carry, auxiliary-carry, zero, sign and parity flags.

A surrounding datapath presents an operation code, the two bytes and the current flags, then pulses `start` for one cycle. One clock later the registered results appear and `done` pulses for one cycle. Between starts the results hold their values. The flag inputs other than carry and auxiliary-carry are not needed: operations that leave zero, sign and parity alone keep the values already registered.

Top module: `bcd_adjust_unit`

## Requirements
- R1: After reset every output is 0.
- R2: A `start` pulse loads the results at the next rising edge and raises `done` for exactly that one cycle. Without `start`, `done` is 0 and every result output holds its value.
- R3: Operation code 0 (unpacked add). Let the condition be: low nibble of the low byte above 9, or incoming AF = 1. When it is true, the low byte becomes low byte + 6 and the high byte becomes high byte + 1, both modulo 256. Otherwise both bytes pass through unchanged.
- R4: Operation code 1 (unpacked subtract) uses the same condition as R3. When it is true, the low byte becomes low byte − 6 and the high byte becomes high byte − 1, both modulo 256.
- R5: For codes 0 and 1, bits 7..4 of the low-byte result are always 0, and CF and AF both equal the condition.
- R6: Operation code 2 (multiply correction) sets the high byte to the integer quotient of the low byte by 10 and the low byte to the remainder. The high-byte input is ignored. Example: 0Fh gives 01h, 05h.
- R7: Operation code 3 (divide preparation) sets the low byte to (high × 10 + low) modulo 256 and the high byte to 0. The divide-error flag is 1 exactly when that sum exceeds 255. Example: 01h, 05h gives 00h, 0Fh.
- R8: Operation code 4 (packed add). First step: if the low nibble is above 9 or AF = 1, add 06h and set AF. Second step: if the original low byte is above 99h or CF = 1, add 60h and set CF. Each flag is cleared when its step is not taken. The high byte passes through. Example: 0Fh gives 15h.
- R9: Operation code 5 (packed subtract) is the same as R8 but subtracts 06h and 60h instead of adding them. Example: FFh gives 99h with CF = 1.
- R10: For codes 2 to 5, ZF is 1 when the final low byte is 0, SF is bit 7 of the final low byte, and PF is 1 when that byte has an even number of 1 bits. Codes 0 and 1 keep ZF, SF and PF unchanged. Codes 2 and 3 clear CF and AF. The divide-error flag is 0 for codes 0, 1, 2, 4 and 5.
- R11: Operation codes 6 and 7 change no result output, but `done` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load results computed from the current inputs |
| op | input | 3 | Operation code (0 to 7) |
| hi_in | input | 8 | Accumulator high byte |
| lo_in | input | 8 | Accumulator low byte |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| hi_out | output | 8 | Result high byte |
| lo_out | output | 8 | Result low byte |
| cf_out | output | 1 | Result carry flag |
| af_out | output | 1 | Result auxiliary-carry flag |
| zf_out | output | 1 | Result zero flag |
| sf_out | output | 1 | Result sign flag |
| pf_out | output | 1 | Result even-parity flag |
| div_err | output | 1 | Divide-preparation sum exceeded 8 bits |
| done | output | 1 | One-cycle pulse after each start |

## Verification
The only state in the unit is the set of result registers. A wrong value there is therefore visible at the ports in the cycle right after the `start` that wrote it. It is also visible in the cycles after that: the zero, sign and parity flags are expected to carry over through codes 0, 1, 6 and 7, so a stale or corrupted flag still shows up one operation later. Each operation code is swept over every low-byte value and all four carry/auxiliary-carry combinations. The divide preparation is also swept over a range of high bytes that crosses the overflow boundary, so a bad nibble test, a missing correction step or a bad flag update shows up at once as a wrong byte or flag.

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic         cf_in,
  input  logic         af_in,
  output logic [W-1:0] hi_out,
  output logic [W-1:0] lo_out,
  output logic         cf_out,
  output logic         af_out,
  output logic         zf_out,
  output logic         sf_out,
  output logic         pf_out,
  output logic         div_err,
  output logic         done
);
  localparam int unsigned SW = W + 4;
  localparam logic [2:0] OP_UADD = 3'd0, OP_USUB = 3'd1, OP_MULA = 3'd2,
                         OP_DIVP = 3'd3, OP_PADD = 3'd4, OP_PSUB = 3'd5;

  logic nib_fix, byte_fix;
  assign nib_fix  = (lo_in[3:0] > 4'd9) | af_in;
  assign byte_fix = (lo_in > W'(8'h99)) | cf_in;

  logic [W-1:0] pa_mid, ps_mid, pa_res, ps_res;
  assign pa_mid = nib_fix  ? lo_in  + W'(8'h06) : lo_in;
  assign ps_mid = nib_fix  ? lo_in  - W'(8'h06) : lo_in;
  assign pa_res = byte_fix ? pa_mid + W'(8'h60) : pa_mid;
  assign ps_res = byte_fix ? ps_mid - W'(8'h60) : ps_mid;

  logic [W-1:0] mul_q, mul_r;
  assign mul_q = lo_in / W'(10);
  assign mul_r = lo_in % W'(10);

  logic [SW-1:0] div_sum;
  assign div_sum = SW'(hi_in) * SW'(10) + SW'(lo_in);

  logic [W-1:0] nx_hi, nx_lo;
  logic nx_cf, nx_af, nx_err, nx_szp, nx_keep;

  always_comb begin
    nx_hi = hi_in; nx_lo = lo_in; nx_cf = 1'b0; nx_af = 1'b0;
    nx_err = 1'b0; nx_szp = 1'b1; nx_keep = 1'b0;
    case (op)
      OP_UADD, OP_USUB: begin
        nx_szp = 1'b0;
        nx_cf  = nib_fix;
        nx_af  = nib_fix;
        if (nib_fix) begin
          nx_lo = {{(W-4){1'b0}}, (op == OP_UADD) ? lo_in[3:0] + 4'd6 : lo_in[3:0] - 4'd6};
          nx_hi = (op == OP_UADD) ? hi_in + W'(1) : hi_in - W'(1);
        end else begin
          nx_lo = {{(W-4){1'b0}}, lo_in[3:0]};
        end
      end
      OP_MULA: begin nx_hi = mul_q; nx_lo = mul_r; end
      OP_DIVP: begin
        nx_hi  = '0;
        nx_lo  = div_sum[W-1:0];
        nx_err = |div_sum[SW-1:W];
      end
      OP_PADD: begin nx_lo = pa_res; nx_af = nib_fix; nx_cf = byte_fix; end
      OP_PSUB: begin nx_lo = ps_res; nx_af = nib_fix; nx_cf = byte_fix; end
      default: nx_keep = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_out <= '0; lo_out <= '0; cf_out <= 1'b0; af_out <= 1'b0;
      zf_out <= 1'b0; sf_out <= 1'b0; pf_out <= 1'b0; div_err <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= start;
      if (start && !nx_keep) begin
        hi_out  <= nx_hi;
        lo_out  <= nx_lo;
        cf_out  <= nx_cf;
        af_out  <= nx_af;
        div_err <= nx_err;
        if (nx_szp) begin
          zf_out <= (nx_lo == '0);
          sf_out <= nx_lo[W-1];
          pf_out <= ~^nx_lo;
        end
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && $stable(lo_out) && $stable(hi_out) && $stable(cf_out)));
  // R5
  unpacked_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == OP_UADD || op == OP_USUB)) |=> (lo_out[W-1:4] == '0 && cf_out == af_out));
  // R6
  mul_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_MULA) |=> (lo_out < W'(10) && !cf_out && !af_out));
  // R7
  div_high_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_DIVP) |=> (hi_out == '0));
  // R10
  unpacked_flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op == OP_UADD || op == OP_USUB)) |=> ($stable(zf_out) && $stable(sf_out) && $stable(pf_out)));
  // R11
  spare_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op[2:1] == 2'b11) |=> ($stable(lo_out) && $stable(hi_out) && $stable(div_err)));
endmodule

// File: tb/bcd_adjust_unit_tb_top.sv
module bcd_adjust_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] hi_in = '0, lo_in = '0;
  logic cf_in = 1'b0, af_in = 1'b0;
  logic [7:0] hi_out, lo_out;
  logic cf_out, af_out, zf_out, sf_out, pf_out, div_err, done;

  int checks = 0, errors = 0;
  int m_hi = 0, m_lo = 0, m_cf = 0, m_af = 0, m_zf = 0, m_sf = 0, m_pf = 0, m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_adjust_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .hi_in(hi_in), .lo_in(lo_in),
    .cf_in(cf_in), .af_in(af_in), .hi_out(hi_out), .lo_out(lo_out), .cf_out(cf_out),
    .af_out(af_out), .zf_out(zf_out), .sf_out(sf_out), .pf_out(pf_out),
    .div_err(div_err), .done(done));

  function automatic string tag(input int o);
    case (o)
      0: return "R3,R5";
      1: return "R4,R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic int even_ones(input int v);
    int n = 0;
    for (int b = 0; b < 8; b++) n += (v >> b) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    int a_data, e_data, a_flg, e_flg;
    a_data = {hi_out, lo_out, cf_out, af_out, div_err};
    e_data = (m_hi << 11) | (m_lo << 3) | (m_cf << 2) | (m_af << 1) | m_err;
    check(a_data == e_data, req, a_data, e_data);
    a_flg = {zf_out, sf_out, pf_out};
    e_flg = (m_zf << 2) | (m_sf << 1) | m_pf;
    check(a_flg == e_flg, "R10", a_flg, e_flg);
  endtask

  task automatic run(input int o, input int h, input int l, input int c, input int a);
    int fix1, fix2, t;
    @(negedge clk);
    op = 3'(o); hi_in = 8'(h); lo_in = 8'(l); cf_in = c[0]; af_in = a[0]; start = 1'b1;
    fix1 = ((l % 16) >= 10 || a != 0) ? 1 : 0;
    fix2 = (l >= 154 || c != 0) ? 1 : 0;
    case (o)
      0, 1: begin
        m_cf = fix1; m_af = fix1; m_err = 0;
        if (fix1 != 0) begin
          m_lo = (o == 0) ? (l + 6) % 16 : (l + 10) % 16;
          m_hi = (o == 0) ? (h + 1) % 256 : (h + 255) % 256;
        end else begin
          m_lo = l % 16; m_hi = h;
        end
      end
      2: begin m_hi = l / 10; m_lo = l - 10 * (l / 10); m_cf = 0; m_af = 0; m_err = 0; end
      3: begin
        t = h * 10 + l;
        m_hi = 0; m_lo = t % 256; m_err = (t > 255) ? 1 : 0; m_cf = 0; m_af = 0;
      end
      4, 5: begin
        t = l;
        if (fix1 != 0) t = (o == 4) ? (t + 6) % 256 : (t + 250) % 256;
        if (fix2 != 0) t = (o == 4) ? (t + 96) % 256 : (t + 160) % 256;
        m_hi = h; m_lo = t; m_af = fix1; m_cf = fix2; m_err = 0;
      end
      default: ;
    endcase
    if (o >= 2 && o <= 5) begin
      m_zf = (m_lo == 0) ? 1 : 0; m_sf = (m_lo >= 128) ? 1 : 0; m_pf = even_ones(m_lo);
    end
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R2", int'(done), 1);
    compare_all(tag(o));
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(done === 1'b0, "R2", int'(done), 0);
    compare_all("R2");
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({hi_out, lo_out, cf_out, af_out, zf_out, sf_out, pf_out, div_err, done} == 0,
          "R1", int'({hi_out, lo_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 R4 R8 R9 R6: every low byte, all carry combinations
    for (int o = 0; o < 6; o++) begin
      if (o == 3) continue;
      for (int l = 0; l < 256; l++)
        for (int f = 0; f < 4; f++)
          run(o, (l * 7 + o * 37 + f) % 256, l, f / 2, f % 2);
    end
    // specific examples
    run(2, 8'hAA, 8'h0F, 0, 0); check(hi_out == 8'h01 && lo_out == 8'h05, "R6", int'({hi_out, lo_out}), 16'h0105);
    run(4, 0, 8'h0F, 0, 0);     check(lo_out == 8'h15, "R8", int'(lo_out), 8'h15);
    run(5, 0, 8'hFF, 0, 0);     check(lo_out == 8'h99 && cf_out, "R9", int'(lo_out), 8'h99);
    run(0, 8'hFF, 8'h0A, 0, 0); check(hi_out == 8'h00 && lo_out == 8'h00, "R3", int'({hi_out, lo_out}), 0);
    run(1, 8'h00, 8'h02, 0, 1); check(hi_out == 8'hFF && lo_out == 8'h0C, "R4", int'({hi_out, lo_out}), 16'hFF0C);
    // R7: divide preparation across the overflow boundary
    for (int h = 0; h < 32; h++)
      for (int l = 0; l < 256; l += 3)
        run(3, h, l, h % 2, (h / 2) % 2);
    run(3, 8'h01, 8'h05, 0, 0); check(lo_out == 8'h0F && hi_out == 0, "R7", int'({hi_out, lo_out}), 16'h000F);
    run(3, 8'd25, 8'd5, 0, 0);  check(div_err == 1'b0 && lo_out == 8'd255, "R7", int'(lo_out), 255);
    run(3, 8'd25, 8'd6, 0, 0);  check(div_err == 1'b1 && lo_out == 8'd0, "R7", int'(lo_out), 0);
    // R10: flags kept through unpacked ops after a flag-setting op
    run(4, 0, 8'h80, 0, 0);
    run(0, 0, 8'h03, 0, 0);
    run(1, 0, 8'h0B, 1, 0);
    // R11: spare codes and R2 idle hold
    run(2, 0, 8'd99, 0, 0);
    for (int o = 6; o < 8; o++) begin
      run(o, 8'h12, 8'h34, 1, 1);
      idle_check();
    end
    repeat (3) idle_check();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule